// File: doc/BRIEF.md
# DDR SDRAM Command and Refresh Scheduler

This block turns single read or write requests into the command stream of a four-bank double-data-rate SDRAM. Each request carries a bank, a row, a column, a direction and an optional auto-precharge flag. The scheduler remembers which row is open in every bank. It opens, closes or reuses rows as needed, and it spaces the commands by per-bank minimum gaps. It also keeps a global write-to-read gap, so that a read never cuts into the burst of a write.

A free-running timer asks for an auto-refresh at a rate derived from the clock frequency: 4096 refreshes per 32 ms window. When that request is pending, new work is refused. Any open bank is closed with a precharge-all, and then the refresh is issued. For every read, the block also produces a data-valid strobe. The strobe is delayed by the programmed CAS latency, counted in half clocks, so it can land on either the rising or the falling half of a clock.

The block is used between a simple request source and the physical command pins. It handles one request at a time, and commands come out in request order.

Top module: `ddr_cmd_sched`

## Requirements
- R1: While reset is held, and at the first cycle after it, `cmd_op` is NOP (0) and both strobes are low. After reset `req_ready` is high and all banks are closed.
- R2: A request to a closed bank issues ACT (1) with `cmd_addr` = row. The read or write follows no earlier than T_RCD cycles after the ACT.
- R3: A request to the row already open in its bank issues the read or write directly, with no ACT or PRE before it.
- R4: A request to an open bank with a different row issues PRE (4), then ACT of the new row no earlier than T_RP cycles later, then the access.
- R5: With auto-precharge, the access carries `cmd_autopre`=1 and the bank is closed afterwards. The next access to that bank starts with ACT, no earlier than BURST_LEN/2+T_RP cycles after the access.
- R6: A read command is never issued sooner than BURST_LEN/2+T_WTR cycles after a write command.
- R7: A refresh falls due every CLK_MHZ*32000/4096 cycles, counted from reset (1953 at 250 MHz). Each REF (6) comes within 40 cycles of its due point.
- R8: REF is issued only with all banks closed, and no earlier than T_RP after a PREA (5). PREA is used when any bank is open. No ACT is issued within T_RFC cycles of a REF.
- R9: `req_ready` is low while a request is in service, and from the moment a refresh falls due until its REF is issued.
- R10: `cas_code` selects the latency: 0 is 2 clocks, 1 is 2.5, 2 is 3 and 3 is 4. A read command in cycle t raises `rd_valid_rise` in cycle t+L for whole latencies L. For 2.5 it raises `rd_valid_fall` in cycle t+2 instead, which marks the second half of that cycle.
- R11: Commands follow request order. RD is 2 and WR is 3, and they carry the column zero-extended in `cmd_addr`. `cmd_bank` names the target bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cas_code | input | 2 | CAS latency select, static while reads are in flight |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the bank after the access |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cmd_op | output | 3 | Command code (NOP/ACT/RD/WR/PRE/PREA/REF) |
| cmd_bank | output | BANK_W | Command bank |
| cmd_addr | output | ROW_W | Row for ACT, column for RD/WR, else 0 |
| cmd_autopre | output | 1 | Auto-precharge flag on RD/WR |
| rd_valid_rise | output | 1 | Read data valid, rising-half phase |
| rd_valid_fall | output | 1 | Read data valid, falling-half phase |

## Verification
Suppose a bank's open flag or stored row were wrong. The scheduler would then emit an ACT where a direct access was due, or the reverse. That mismatch appears on `cmd_op` at the first command of the next request to that bank. A timer that expires early shows up as a command that comes too soon after an ACT, PRE, REF or WR. Such a command is visible at the very edge it is issued. A wrong latency tap shows up as a strobe in the wrong cycle or on the wrong phase, two to four cycles after the read.

// File: rtl/ddr_sched_pkg.sv
package ddr_sched_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_PREA = 3'd5,
    OP_REF  = 3'd6
  } cmd_op_e;

  typedef enum logic {ST_IDLE, ST_SERVE} sched_st_e;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot #(
  parameter int ROW_W = 12,
  parameter int TMR_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_open_i,
  input  logic             clr_open_i,
  input  logic             ld_i,
  input  logic [TMR_W-1:0] ld_val_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             ready_o
);
  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      row_q  <= '0;
      tmr_q  <= '0;
    end else begin
      if (set_open_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
      end else if (clr_open_i) begin
        open_q <= 1'b0;
      end
      if (ld_i)               tmr_q <= ld_val_i;
      else if (tmr_q != '0)   tmr_q <= tmr_q - 1'b1;
    end
  end

  assign open_o  = open_q;
  assign row_o   = row_q;
  assign ready_o = (tmr_q == '0);

  // R2: an activate lands only on a closed bank whose gap has elapsed
  a_r2_act_when_closed: assert property (@(posedge clk) disable iff (rst)
    set_open_i |-> (!open_q && tmr_q == '0));
  // R4: a precharge only closes a bank that is open
  a_r4_close_when_open: assert property (@(posedge clk) disable iff (rst)
    clr_open_i |-> open_q);
endmodule

// File: rtl/ddr_refresh_timer.sv
module ddr_refresh_timer #(
  parameter int INTERVAL = 1953
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_i,
  output logic due_o
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt_q;
  logic          due_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      due_q <= 1'b0;
    end else begin
      if (cnt_q == CW'(INTERVAL - 1)) begin
        cnt_q <= '0;
        due_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (ack_i) due_q <= 1'b0;
      end
    end
  end

  assign due_o = due_q;

  // R7: a pending refresh stays pending until it is acknowledged
  a_r7_due_held: assert property (@(posedge clk) disable iff (rst)
    (due_q && !ack_i) |=> due_q);
  // R7: a refresh is only acknowledged when one is due
  a_r7_ack_needs_due: assert property (@(posedge clk) disable iff (rst)
    ack_i |-> due_q);
endmodule

// File: rtl/ddr_cas_strobe.sv
module ddr_cas_strobe #(
  parameter int MAX_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_issued_i,
  input  logic [1:0] cas_code_i,
  output logic       rise_o,
  output logic       fall_o
);
  logic [MAX_CYC-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[MAX_CYC-2:0], rd_issued_i};
  end

  // tap k of the pipe is high k+1 cycles after the read command cycle
  always_comb begin
    rise_o = 1'b0;
    fall_o = 1'b0;
    case (cas_code_i)
      2'd0: rise_o = pipe_q[1];
      2'd1: fall_o = pipe_q[1];
      2'd2: rise_o = pipe_q[2];
      default: rise_o = pipe_q[3];
    endcase
  end

  // R10: a strobe picks exactly one phase
  a_r10_one_phase: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/ddr_cmd_sched.sv
module ddr_cmd_sched import ddr_sched_pkg::*; #(
  parameter int NUM_BANKS    = 4,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 8,
  parameter int CLK_MHZ      = 250,
  parameter int REF_WIN_US   = 32000,
  parameter int REF_PER_WIN  = 4096,
  parameter int T_RCD        = 4,
  parameter int T_RP         = 4,
  parameter int T_RFC        = 18,
  parameter int T_WTR        = 2,
  parameter int BURST_LEN    = 4,
  parameter int BANK_W       = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cas_code,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_autopre,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic [2:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_addr,
  output logic              cmd_autopre,
  output logic              rd_valid_rise,
  output logic              rd_valid_fall
);
  localparam int BURST_CYC = BURST_LEN / 2;
  localparam int WTR_CYC   = BURST_CYC + T_WTR;
  localparam int AP_GAP    = BURST_CYC + T_RP;
  localparam int REF_CYC   = CLK_MHZ * REF_WIN_US / REF_PER_WIN;
  localparam int MAX_GAP   = max2(max2(T_RFC, AP_GAP), max2(T_RCD, T_RP));
  localparam int TMR_W     = $clog2(MAX_GAP + 1);
  localparam int WB_W      = $clog2(WTR_CYC + 1);
  localparam int SW_W      = $clog2(WTR_CYC + 2);
  localparam logic [TMR_W-1:0] RCD_LD = TMR_W'(T_RCD - 1);
  localparam logic [TMR_W-1:0] RP_LD  = TMR_W'(T_RP - 1);
  localparam logic [TMR_W-1:0] RFC_LD = TMR_W'(T_RFC - 1);
  localparam logic [TMR_W-1:0] AP_LD  = TMR_W'(AP_GAP - 1);

  // request holding registers
  sched_st_e         st_q;
  logic              rq_write, rq_ap;
  logic [BANK_W-1:0] rq_bank;
  logic [ROW_W-1:0]  rq_row;
  logic [COL_W-1:0]  rq_col;

  // command registers
  cmd_op_e           cmd_q, nxt_op;
  logic [BANK_W-1:0] cmd_bank_q, nxt_bank;
  logic [ROW_W-1:0]  cmd_addr_q, nxt_addr;
  logic              cmd_ap_q, nxt_ap;
  logic              done, ref_ack, ref_due, accept;
  logic [WB_W-1:0]   wr_blk_q;

  // per-bank state
  logic [NUM_BANKS-1:0] set_v, clr_v, ld_v, bank_open, bank_ready;
  logic [TMR_W-1:0]     ld_val [NUM_BANKS];
  logic [ROW_W-1:0]     bank_row [NUM_BANKS];

  genvar g;
  generate
    for (g = 0; g < NUM_BANKS; g++) begin : g_bank
      ddr_bank_slot #(.ROW_W(ROW_W), .TMR_W(TMR_W)) i_slot (
        .clk(clk), .rst(rst),
        .set_open_i(set_v[g]), .clr_open_i(clr_v[g]),
        .ld_i(ld_v[g]), .ld_val_i(ld_val[g]), .row_i(rq_row),
        .open_o(bank_open[g]), .row_o(bank_row[g]), .ready_o(bank_ready[g])
      );
    end
  endgenerate

  ddr_refresh_timer #(.INTERVAL(REF_CYC)) i_ref (
    .clk(clk), .rst(rst), .ack_i(ref_ack), .due_o(ref_due)
  );

  ddr_cas_strobe #(.MAX_CYC(4)) i_cas (
    .clk(clk), .rst(rst), .rd_issued_i(cmd_q == OP_RD),
    .cas_code_i(cas_code), .rise_o(rd_valid_rise), .fall_o(rd_valid_fall)
  );

  assign req_ready = (st_q == ST_IDLE) && !ref_due;
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt_op   = OP_NOP;
    nxt_bank = '0;
    nxt_addr = '0;
    nxt_ap   = 1'b0;
    done     = 1'b0;
    ref_ack  = 1'b0;
    set_v    = '0;
    clr_v    = '0;
    ld_v     = '0;
    for (int k = 0; k < NUM_BANKS; k++) ld_val[k] = '0;

    if (st_q == ST_IDLE) begin
      if (ref_due && (&bank_ready)) begin
        if (|bank_open) begin
          nxt_op = OP_PREA;
          for (int k = 0; k < NUM_BANKS; k++) begin
            clr_v[k]  = bank_open[k];
            ld_v[k]   = 1'b1;
            ld_val[k] = RP_LD;
          end
        end else begin
          nxt_op  = OP_REF;
          ref_ack = 1'b1;
          for (int k = 0; k < NUM_BANKS; k++) begin
            ld_v[k]   = 1'b1;
            ld_val[k] = RFC_LD;
          end
        end
      end
    end else if (bank_ready[rq_bank]) begin
      nxt_bank = rq_bank;
      if (!bank_open[rq_bank]) begin
        nxt_op            = OP_ACT;
        nxt_addr          = rq_row;
        set_v[rq_bank]    = 1'b1;
        ld_v[rq_bank]     = 1'b1;
        ld_val[rq_bank]   = RCD_LD;
      end else if (bank_row[rq_bank] != rq_row) begin
        nxt_op            = OP_PRE;
        clr_v[rq_bank]    = 1'b1;
        ld_v[rq_bank]     = 1'b1;
        ld_val[rq_bank]   = RP_LD;
      end else if (rq_write || wr_blk_q == '0) begin
        nxt_op   = rq_write ? OP_WR : OP_RD;
        nxt_addr = ROW_W'(rq_col);
        nxt_ap   = rq_ap;
        done     = 1'b1;
        if (rq_ap) begin
          clr_v[rq_bank]  = 1'b1;
          ld_v[rq_bank]   = 1'b1;
          ld_val[rq_bank] = AP_LD;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      rq_write   <= 1'b0;
      rq_ap      <= 1'b0;
      rq_bank    <= '0;
      rq_row     <= '0;
      rq_col     <= '0;
      cmd_q      <= OP_NOP;
      cmd_bank_q <= '0;
      cmd_addr_q <= '0;
      cmd_ap_q   <= 1'b0;
      wr_blk_q   <= '0;
    end else begin
      cmd_q      <= nxt_op;
      cmd_bank_q <= nxt_bank;
      cmd_addr_q <= nxt_addr;
      cmd_ap_q   <= nxt_ap;
      if (accept) begin
        st_q     <= ST_SERVE;
        rq_write <= req_write;
        rq_ap    <= req_autopre;
        rq_bank  <= req_bank;
        rq_row   <= req_row;
        rq_col   <= req_col;
      end else if (done) begin
        st_q <= ST_IDLE;
      end
      if (nxt_op == OP_WR)       wr_blk_q <= WB_W'(WTR_CYC - 1);
      else if (wr_blk_q != '0)   wr_blk_q <= wr_blk_q - 1'b1;
    end
  end

  assign cmd_op      = cmd_q;
  assign cmd_bank    = cmd_bank_q;
  assign cmd_addr    = cmd_addr_q;
  assign cmd_autopre = cmd_ap_q;

  // independent cycles-since-write counter for the read gap check
  logic [SW_W-1:0] since_wr_q;
  always_ff @(posedge clk) begin
    if (rst)                                   since_wr_q <= SW_W'(WTR_CYC);
    else if (cmd_q == OP_WR)                   since_wr_q <= SW_W'(1);
    else if (since_wr_q < SW_W'(WTR_CYC))      since_wr_q <= since_wr_q + 1'b1;
  end

  // R6: a read on the bus is at least the write-to-read gap after a write
  a_r6_rd_after_wr: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == OP_RD) |-> (since_wr_q >= SW_W'(WTR_CYC)));
  // R8: a refresh on the bus sees every bank closed
  a_r8_ref_all_closed: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == OP_REF) |-> (bank_open == '0));
  // R9: with refresh due, no new request leaves the idle state
  a_r9_refresh_first: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && ref_due) |=> (st_q == ST_IDLE));
endmodule

// File: tb/test_ddr_cmd_sched.sv
module test_ddr_cmd_sched;
  localparam int ROW_W = 12, COL_W = 8, BANK_W = 2;
  localparam int T_RCD = 4, T_RP = 4, T_RFC = 18, T_WTR = 2, BURST_LEN = 4;
  localparam int WTR_CYC = BURST_LEN / 2 + T_WTR;
  localparam int AP_GAP  = BURST_LEN / 2 + T_RP;
  localparam int REF_CYC = 250 * 32000 / 4096;

  logic clk = 0, rst = 1;
  logic [1:0] cas_code = 0;
  logic req_valid = 0, req_write = 0, req_autopre = 0, req_ready;
  logic [BANK_W-1:0] req_bank = 0;
  logic [ROW_W-1:0]  req_row = 0;
  logic [COL_W-1:0]  req_col = 0;
  logic [2:0] cmd_op;
  logic [BANK_W-1:0] cmd_bank;
  logic [ROW_W-1:0]  cmd_addr;
  logic cmd_autopre, rd_valid_rise, rd_valid_fall;

  ddr_cmd_sched i_ddr_cmd_sched (
    .clk(clk), .rst(rst), .cas_code(cas_code),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_autopre(req_autopre), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_autopre(cmd_autopre),
    .rd_valid_rise(rd_valid_rise), .rd_valid_fall(rd_valid_fall)
  );

  always #2 clk = ~clk;

  int cyc = 0, errors = 0, checks = 0;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  // behavioural reference state
  bit m_open[4];
  int m_row[4], m_close_at[4], m_gap[4], m_act_at[4];
  int last_wr = -1000, last_ref = 0, refs = 0, cas_now = 0;
  int q_op[$], q_bank[$], q_addr[$], q_ap[$];
  int s_cyc[$], s_ph[$];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin
      m_open[k] = 0; m_row[k] = 0; m_close_at[k] = -1000; m_gap[k] = 0; m_act_at[k] = -1000;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    int op, b, a, half;
    bit er, ef, any;
    if (!rst) begin
      op = int'(cmd_op); b = int'(cmd_bank); a = int'(cmd_addr);
      if (op == 5) begin
        any = 0;
        for (int k = 0; k < 4; k++) any |= m_open[k];
        chk(any, "R8 PREA with an open bank", 0, 1);
        for (int k = 0; k < 4; k++) begin
          m_open[k] = 0; m_close_at[k] = cyc; m_gap[k] = T_RP;
        end
      end else if (op == 6) begin
        for (int k = 0; k < 4; k++) begin
          chk(!m_open[k], "R8 bank closed at REF", int'(m_open[k]), 0);
          chk(cyc - m_close_at[k] >= m_gap[k], "R8 gap before REF", cyc - m_close_at[k], m_gap[k]);
        end
        if (refs == 0)
          chk(cyc >= REF_CYC && cyc <= REF_CYC + 40, "R7 first REF", cyc, REF_CYC);
        else
          chk(cyc - last_ref >= REF_CYC - 40 && cyc - last_ref <= REF_CYC + 40,
              "R7 REF spacing", cyc - last_ref, REF_CYC);
        last_ref = cyc; refs++;
        for (int k = 0; k < 4; k++) begin
          m_close_at[k] = cyc; m_gap[k] = T_RFC;
        end
      end else if (op != 0) begin
        if (q_op.size() == 0) begin
          chk(0, "R11 unexpected command", op, 0);
        end else begin
          chk(op == q_op[0] && b == q_bank[0] && a == q_addr[0] && int'(cmd_autopre) == q_ap[0],
              "R11 command fields",
              ((op * 4 + b) * 8192 + a) * 2 + int'(cmd_autopre),
              ((q_op[0] * 4 + q_bank[0]) * 8192 + q_addr[0]) * 2 + q_ap[0]);
          void'(q_op.pop_front()); void'(q_bank.pop_front());
          void'(q_addr.pop_front()); void'(q_ap.pop_front());
          if (op == 1) begin
            chk(!m_open[b], "R2 ACT on closed bank", int'(m_open[b]), 0);
            chk(cyc - m_close_at[b] >= m_gap[b], "R4 R5 R8 gap before ACT",
                cyc - m_close_at[b], m_gap[b]);
            m_open[b] = 1; m_row[b] = a; m_act_at[b] = cyc;
          end else if (op == 4) begin
            chk(m_open[b], "R4 PRE on open bank", int'(m_open[b]), 1);
            m_open[b] = 0; m_close_at[b] = cyc; m_gap[b] = T_RP;
          end else if (op == 2 || op == 3) begin
            chk(m_open[b], "R3 access to open bank", int'(m_open[b]), 1);
            chk(cyc - m_act_at[b] >= T_RCD, "R2 ACT to access gap", cyc - m_act_at[b], T_RCD);
            if (op == 2) begin
              chk(cyc - last_wr >= WTR_CYC, "R6 write to read gap", cyc - last_wr, WTR_CYC);
              half = (cas_now == 0) ? 4 : (cas_now == 1) ? 5 : (cas_now == 2) ? 6 : 8;
              s_cyc.push_back(cyc + half / 2); s_ph.push_back(half % 2);
            end else begin
              last_wr = cyc;
            end
            if (cmd_autopre) begin
              m_open[b] = 0; m_close_at[b] = cyc; m_gap[b] = AP_GAP;
            end
          end
        end
      end
      er = 0; ef = 0;
      if (s_cyc.size() != 0 && s_cyc[0] == cyc) begin
        if (s_ph[0] == 1) ef = 1; else er = 1;
        void'(s_cyc.pop_front()); void'(s_ph.pop_front());
      end
      chk(rd_valid_rise == er && rd_valid_fall == ef, "R10 read strobe",
          int'({rd_valid_rise, rd_valid_fall}), int'({er, ef}));
      if ((cyc - 2) / REF_CYC > refs)
        chk(req_ready == 0, "R9 ready low while refresh due", int'(req_ready), 0);
    end
  end

  task automatic send(bit w, bit ap, int b, int row, int col);
    @(negedge clk); #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (m_open[b] && m_row[b] != row) begin
      q_op.push_back(4); q_bank.push_back(b); q_addr.push_back(0); q_ap.push_back(0);
    end
    if (!m_open[b] || m_row[b] != row) begin
      q_op.push_back(1); q_bank.push_back(b); q_addr.push_back(row); q_ap.push_back(0);
    end
    q_op.push_back(w ? 3 : 2); q_bank.push_back(b); q_addr.push_back(col); q_ap.push_back(int'(ap));
    req_write = w; req_autopre = ap; req_bank = BANK_W'(b);
    req_row = ROW_W'(row); req_col = COL_W'(col); req_valid = 1;
    @(negedge clk); #1;
    req_valid = 0;
    chk(req_ready == 0, "R9 ready low during service", int'(req_ready), 0);
  endtask

  task automatic drain();
    while (q_op.size() != 0 || s_cyc.size() != 0) begin @(negedge clk); #1; end
    repeat (12) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_op == 0, "R1 NOP in reset", int'(cmd_op), 0);
    chk(!rd_valid_rise && !rd_valid_fall, "R1 strobes low in reset",
        int'({rd_valid_rise, rd_valid_fall}), 0);
    rst = 0;
    @(negedge clk); #1;
    chk(req_ready == 1, "R1 ready after reset", int'(req_ready), 1);
    chk(cmd_op == 0, "R1 NOP after reset", int'(cmd_op), 0);
    // directed: closed bank, write then read of same row, row miss, auto-precharge
    send(1, 0, 0, 10, 5);
    send(0, 0, 0, 10, 6);
    send(0, 0, 0, 11, 7);
    send(1, 1, 1, 3, 8);
    send(0, 0, 1, 3, 9);
    send(1, 0, 2, 40, 1);
    send(0, 1, 2, 40, 2);
    for (int code = 0; code < 4; code++) begin
      drain();
      cas_code = 2'(code); cas_now = code;
      for (int i = 0; i < 60; i++)
        send(i % 3 == 0, i % 7 == 3, i % 4, ((i * 7) / 5) % 3 + (i % 4) * 4, (i * 13) % 256);
    end
    drain();
    repeat (5000) @(negedge clk);
    #1;
    chk(refs >= 3, "R7 refresh count", refs, (cyc - 2) / REF_CYC);
    chk(refs == (cyc - 40) / REF_CYC || refs == (cyc - 2) / REF_CYC, "R7 refresh count matches time",
        refs, (cyc - 2) / REF_CYC);
    report();
  end
endmodule